// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is the slave end of a stereo serial audio link. Three inputs come from outside: a bit clock, a word-select line and a serial data input. The block drives a serial data output. It runs on a faster system clock and watches for edges on the bit clock. Received data is sampled on the rising bit-clock edge, and the transmitted bit changes after the falling edge. Word select must change on a falling bit-clock edge.

On the receive side, the block puts the left and right words of each finished frame onto two 24-bit buses and pulses a one-cycle strobe. On the transmit side, it copies the core's left or right word at the start of each half-frame and sends it out serially.

A 2-bit format input picks one of four framings:
- I2S.
- MSB-justified.
- LSB-justified.
- A combined mode that receives LSB-justified data and transmits MSB-justified data.

A 2-bit length input picks the LSB-justified word length.

Top module: `serial_audio_port`

## Requirements
- R1: Serial input is sampled when a rising bit-clock edge is seen. The serial output changes only in the system-clock cycle after a falling bit-clock edge is detected.
- R2: Format code 0 (I2S): the word MSB occupies the second slot after a word-select change. Bit i of the 24-bit word (counting from the MSB) is in slot i+1. This holds in both directions.
- R3: Format code 1 (MSB-justified): bit i counting from the MSB occupies slot i after the word-select change. This holds in both directions.
- R4: Format code 2 (LSB-justified) uses a word length N selected by the length code: 0→16, 1→18, 2→20, 3→24.
  - Receive keeps the last N bits of the half-frame and presents them MSB-aligned with zero low bits.
  - Transmit sends the top N bits of the core word so that its last bit falls in the final slot. The half-frame length used is the length measured in the preceding half-frame.
- R5: Format code 3 receives as in R4 and transmits as in R3.
- R6: Word select low is the left channel and high is the right. The left transmit input is captured when a left half-frame begins, and the right transmit input when a right half-frame begins.
- R7: The receive strobe is a one-cycle pulse at the start of each left half-frame. It updates both receive words of the frame just completed together. Between strobes, the receive words hold.
- R8: In formats 0 and 1, word bits that have no slot in a short half-frame are received as zero. Slots beyond the 24th carry zero on transmit.
- R9: Reset clears the receive words, the strobe and the serial output.
- R10: Half-frames of up to 64 slots (bit clock up to 128 times the word-select rate) are handled. The slot counters saturate rather than wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word select, low = left |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| fmt | input | 2 | Framing: 0 I2S, 1 MSB-justified, 2 LSB-justified, 3 combined |
| wlen | input | 2 | LSB-justified length: 16/18/20/24 |
| tx_left | input | 24 | Left word to transmit |
| tx_right | input | 24 | Right word to transmit |
| rx_left | output | 24 | Last received left word |
| rx_right | output | 24 | Last received right word |
| rx_valid | output | 1 | One-cycle frame strobe |

## Verification
The bench covers every format and length with half-frames of 16, 24, 32 and 64 slots. This exposes the following faults:
- An I2S path that drops the final bit carried in the next half's first slot would lose the LSB of 24-bit words in 24-slot frames.
- An LSB-justified transmitter that miscounts the half length would shift every word by a slot.
- Sixteen-slot frames check zero-fill. A design that leaves stale bits in the receive word would show them there.
- The 64-slot case catches a slot counter that wraps too early.
- The combined mode would show a mismatch if the receive and transmit justifications were tied together.

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
  parameter int W = 24,
  parameter int MAXSLOT = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bck_i,
  input  logic         ws_i,
  input  logic         sd_i,
  output logic         sd_o,
  input  logic [1:0]   fmt,
  input  logic [1:0]   wlen,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right,
  output logic         rx_valid
);
  localparam int CW = $clog2(MAXSLOT + 1) + 1;
  localparam logic [W-1:0] TOPBIT = {1'b1, {(W-1){1'b0}}};

  logic bck_q, bck_d, ws_q, sd_q;
  logic rise, fall;
  int   nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_q <= 1'b0; bck_d <= 1'b0; ws_q <= 1'b0; sd_q <= 1'b0;
    end else begin
      bck_q <= bck_i; bck_d <= bck_q; ws_q <= ws_i; sd_q <= sd_i;
    end
  end

  assign rise = bck_q & ~bck_d;
  assign fall = ~bck_q & bck_d;

  always_comb begin
    case (wlen)
      2'd0:    nbits = 16;
      2'd1:    nbits = 18;
      2'd2:    nbits = 20;
      default: nbits = W;
    endcase
  end

  // receive side
  logic          r_ws, r_sync, r_edge;
  logic [CW-1:0] rcnt;
  logic [W-1:0]  racc, rsh, rpend, rfin;
  int            ridx;

  assign r_edge = rise & (ws_q != r_ws);
  assign ridx   = (fmt == 2'd0) ? int'(rcnt) : int'(rcnt) + 1;

  always_comb begin
    rfin = racc;
    if (fmt[1])
      rfin = rsh << (W - nbits);
    else if (fmt == 2'd0 && int'(rcnt) < W)
      rfin = racc | ({sd_q, {(W-1){1'b0}}} >> rcnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_ws <= 1'b1; r_sync <= 1'b0; rcnt <= '0;
      racc <= '0; rsh <= '0; rpend <= '0;
      rx_left <= '0; rx_right <= '0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        r_ws <= ws_q;
        if (r_edge) begin
          rsh    <= {{(W-1){1'b0}}, sd_q};
          rcnt   <= '0;
          racc   <= (fmt == 2'd1) ? (sd_q ? TOPBIT : '0) : '0;
          r_sync <= 1'b1;
          if (r_sync) begin
            if (!r_ws) rpend <= rfin;
            else begin
              rx_left  <= rpend;
              rx_right <= rfin;
              rx_valid <= 1'b1;
            end
          end
        end else begin
          rsh <= {rsh[W-2:0], sd_q};
          if (int'(rcnt) < MAXSLOT) rcnt <= rcnt + 1'b1;
          if (ridx < W) racc <= racc | ({sd_q, {(W-1){1'b0}}} >> ridx);
        end
      end
    end
  end

  // transmit side
  logic          t_ws, t_edge, tbit;
  logic [CW-1:0] tcnt, tlen;
  logic [W-1:0]  tcur, tword, tsh;
  int            tslot, tidx, tnb, tl;

  assign t_edge = fall & (ws_q != t_ws);
  assign tslot  = t_edge ? 0 : int'(tcnt) + 1;

  always_comb begin
    tword = t_edge ? (ws_q ? tx_right : tx_left) : tcur;
    tl    = t_edge ? int'(tcnt) + 1 : int'(tlen);
    tnb   = W;
    case (fmt)
      2'd0: begin tidx = int'(tcnt); tword = tcur; end
      2'd2: begin tidx = tslot + nbits - tl; tnb = nbits; end
      default: tidx = tslot;
    endcase
    tsh  = (tidx >= 0 && tidx < tnb) ? (tword << tidx) : '0;
    tbit = tsh[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_ws <= 1'b1; tcnt <= '0; tlen <= '0; tcur <= '0; sd_o <= 1'b0;
    end else if (fall) begin
      t_ws <= ws_q;
      sd_o <= tbit;
      if (t_edge) begin
        tcnt <= '0;
        tlen <= tcnt + 1'b1;
        tcur <= ws_q ? tx_right : tx_left;
      end else if (int'(tcnt) < MAXSLOT) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_audio_port_chk.sv
module serial_audio_port_chk #(
  parameter int W = 24,
  parameter int MAXSLOT = 64,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sd_o,
  input logic          rx_valid,
  input logic [W-1:0]  rx_left,
  input logic [W-1:0]  rx_right,
  input logic          fall,
  input logic          r_ws,
  input logic [CW-1:0] rcnt,
  input logic [CW-1:0] tcnt
);
  assert_sdo_after_fall_R1: assert property (@(posedge clk) disable iff (rst)
    (sd_o != $past(sd_o)) |-> $past(fall));

  assert_strobe_on_left_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (r_ws == 1'b0));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_words_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((rx_left != $past(rx_left)) || (rx_right != $past(rx_right))) |-> rx_valid);

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!rx_valid && !sd_o && rx_left == '0 && rx_right == '0));

  assert_slot_sat_R10: assert property (@(posedge clk) disable iff (rst)
    (int'(rcnt) <= MAXSLOT) && (int'(tcnt) <= MAXSLOT));
endmodule

bind serial_audio_port serial_audio_port_chk #(.W(W), .MAXSLOT(MAXSLOT), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .sd_o(sd_o), .rx_valid(rx_valid),
  .rx_left(rx_left), .rx_right(rx_right), .fall(fall),
  .r_ws(r_ws), .rcnt(rcnt), .tcnt(tcnt)
);

// File: tb/serial_audio_port_tb.sv
`timescale 1ns/1ps
module serial_audio_port_tb_top;
  localparam int NF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bck = 1'b1, ws = 1'b1, sdi = 1'b0;
  logic sdo;
  logic [1:0] fmt = 2'd0, wlen = 2'd0;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic [23:0] rx_left, rx_right;
  logic rx_valid;
  int checks = 0, fails = 0, nstb = 0, cur_cfg = 0;

  always #2.5 clk = ~clk;

  serial_audio_port dut_i (
    .clk(clk), .rst(rst), .bck_i(bck), .ws_i(ws), .sd_i(sdi), .sd_o(sdo),
    .fmt(fmt), .wlen(wlen), .tx_left(tx_left), .tx_right(tx_right),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  always @(posedge clk) if (!rst && rx_valid) nstb++;

  function automatic logic [23:0] rxw(int f, int h);
    return 24'((f + 3) * 32'h9E3779 ^ (h + 1) * 32'h5A5A5A ^ cur_cfg * 32'h13579);
  endfunction

  function automatic logic [23:0] txw(int f, int h);
    return 24'((f + 7) * 32'h7F4A7C ^ (h + 5) * 32'h2C1B3D ^ cur_cfg * 32'h24680B);
  endfunction

  function automatic logic [23:0] topmask(int m);
    return ~((24'h1 << (24 - m)) - 24'h1);
  endfunction

  function automatic logic slot_bit(int kind, int n, int S, int k,
                                    logic [23:0] w, logic [23:0] wp);
    int idx;
    if (kind == 0) begin
      if (k == 0) return (S - 1 < 24) ? wp[23 - (S - 1)] : 1'b0;
      idx = k - 1;
      return (idx < 24) ? w[23 - idx] : 1'b0;
    end
    if (kind == 1) return (k < 24) ? w[23 - k] : 1'b0;
    idx = k - (S - n);
    return (idx >= 0 && idx < n) ? w[23 - idx] : 1'b0;
  endfunction

  task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cfg=%0d actual=%h expected=%h", req, cur_cfg, act, exp);
    end
  endtask

  task automatic do_slot(logic w, logic b, output logic got);
    @(negedge clk);
    bck = 1'b0; ws = w; sdi = b;
    repeat (3) @(negedge clk);
    bck = 1'b1;
    repeat (3) @(negedge clk);
    got = sdo;
  endtask

  task automatic run_cfg(int fm, int wl, int S);
    int n, rk, tk, ntx, m, st0, mism;
    logic got, expb, ab, eb;
    logic [23:0] wp;
    n   = (wl == 0) ? 16 : (wl == 1) ? 18 : (wl == 2) ? 20 : 24;
    rk  = (fm >= 2) ? 2 : fm;
    tk  = (fm == 0) ? 0 : (fm == 2) ? 2 : 1;
    ntx = (tk == 2) ? n : 24;
    m   = (fm < 2) ? ((S < 24) ? S : 24) : n;
    fmt = 2'(fm); wlen = 2'(wl);
    bck = 1'b1; ws = 1'b1; sdi = 1'b0; rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(!rx_valid && rx_left == 0 && rx_right == 0 && !sdo, "R9 reset",
          {rx_left[22:0], sdo}, 24'h0);
    st0 = nstb;
    for (int f = 0; f < NF; f++) begin
      tx_left = txw(f, 0); tx_right = txw(f, 1);
      for (int h = 0; h < 2; h++) begin
        mism = 0; ab = 1'b0; eb = 1'b0;
        for (int k = 0; k < S; k++) begin
          wp = (h == 0) ? rxw(f - 1, 1) : rxw(f, 0);
          do_slot(h[0], slot_bit(rk, n, S, k, rxw(f, h), wp), got);
          if (f >= 1) begin
            wp = (h == 0) ? txw(f - 1, 1) : txw(f, 0);
            expb = slot_bit(tk, ntx, S, k, txw(f, h), wp);
            if (got !== expb && mism == 0) begin ab = got; eb = expb; end
            if (got !== expb) mism++;
          end
          if (f >= 1 && h == 0 && k == 0) begin
            // R2 R3 R4 R5 R6 R8 R10: receive words of the previous frame
            check(rx_left == (rxw(f - 1, 0) & topmask(m)), "R6 R2/R3/R4/R5/R8 rx left",
                  rx_left, rxw(f - 1, 0) & topmask(m));
            check(rx_right == (rxw(f - 1, 1) & topmask(m)), "R6 R2/R3/R4/R5/R8 rx right",
                  rx_right, rxw(f - 1, 1) & topmask(m));
            check(nstb - st0 == f, "R7 strobe count", 24'(nstb - st0), 24'(f));
          end
        end
        if (f >= 1)
          // R1 R2 R3 R4 R5 R8 R10: transmitted half-frame
          check(mism == 0, (S == 64) ? "R10 R1 tx half" : "R1 R2/R3/R4/R5 tx half",
                {23'(mism), ab}, {23'h0, eb});
      end
    end
  endtask

  initial begin
    int S;
    for (int fm = 0; fm < 4; fm++)
      for (int wl = 0; wl < 4; wl++)
        for (int si = 0; si < 4; si++) begin
          S = (si == 0) ? 16 : (si == 1) ? 24 : (si == 2) ? 32 : 64;
          if (fm < 2 && wl != 0) continue;
          if (fm >= 2 && S < ((wl == 0) ? 16 : (wl == 1) ? 18 : (wl == 2) ? 20 : 24)) continue;
          cur_cfg++;
          run_cfg(fm, wl, S);
        end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog cfg=%0d actual=timeout expected=done", cur_cfg);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule